// File: doc/BRIEF.md
# Double-Buffered Serial Word Transmitter

This block sends words of 8 to 32 bits out on one serial data line. A host loads each word through a 16-bit write port in two halves, upper first and lower second. Writing the lower half commits the word to a holding stage. From there it moves into a shift stage that is also split into two 16-bit halves. The block runs on the bit clock: `clk_i` is the serial bit clock, and the host port is synchronous to it.

A committed word moves into the shift stage on the next clock if the shifter is empty. If the shifter is busy, the word moves on the clock that ends the last bit of the current word. A loaded word does not go out on the line until a transmit frame sync is sampled. The holding stage frees up when its word moves on, so the host can queue the next word while the current one is still shifting.

Top module: `sertx_dbuf_tx`

## Requirements
- R1: While reset is held and right after it is released, `sdo_o` is 0, `tx_ready_o` is 1 and `ovf_o` is 0.
- R2: A write with `wr_hi_i`=1 loads the upper half (word bits 31:16). A write with `wr_hi_i`=0 loads the lower half (bits 15:0) and commits the word, so `tx_ready_o` is 0 in the following cycle.
- R3: If the shift stage holds no word, a committed word moves into it on the next clock edge, and `tx_ready_o` returns to 1.
- R4: If the shift stage is busy, the committed word stays in the holding stage (`tx_ready_o`=0). It moves on the clock edge that ends the last bit of the current word, and it then waits for its own frame sync.
- R5: A loaded word starts only when `fsync_i` is sampled high while that word is loaded and not yet shifting. Its first bit appears on `sdo_o` in the cycle after that edge. Without a frame sync the line stays low.
- R6: Bits go out MSB first, one per clock. For a length L, the word is right-justified in {upper, lower}, so bit L-1 goes first and bit 0 goes last.
- R7: `len_m1_i` gives L-1 and is latched when the word enters the shift stage. Values below 7 count as 7, so the word is 8 bits long.
- R8: `sdo_o` is 0 whenever no word is shifting. A frame sync with no word loaded has no effect, and it is not remembered for a word committed later.
- R9: A frame sync that arrives while a word is shifting is ignored. The current word keeps going without a break.
- R10: Writing the lower half while the holding stage is full, with no transfer out in that cycle, replaces the pending word and sets `ovf_o`. `ovf_o` stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| wr_hi_i | input | 1 | Half select: 1 selects the upper half, 0 selects the lower half and commits |
| wr_data_i | input | 16 | Host write data |
| len_m1_i | input | 5 | Word length minus one |
| fsync_i | input | 1 | Transmit frame sync |
| sdo_o | output | 1 | Serial data out |
| tx_ready_o | output | 1 | Holding stage is empty |
| ovf_o | output | 1 | Sticky overwrite flag |

## Verification
The bench queues a second word while the first is still shifting, and checks that it is sent whole after the last bit and a new frame sync. A design that transferred at once would corrupt the word on the line, and one that never reloaded would send nothing. The bench also sends frame syncs with no word loaded and in the middle of a word. A design that latched the early sync would start without one, and one that honoured the mid-word sync would restart or cut the word short. A short length field and a double commit are covered as well: the first shows whether the 8-bit minimum is applied, and the second shows whether the newer word replaces the pending one and the sticky flag is raised.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int unsigned HALF_W   = 16;
  localparam int unsigned NUM_HALF = 2;
  localparam int unsigned WORD_W   = HALF_W * NUM_HALF;
  localparam int unsigned CNT_W    = $clog2(WORD_W);
  localparam int unsigned MIN_LEN  = 8;
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int unsigned HALF_W   = sertx_pkg::HALF_W,
  parameter int unsigned NUM_HALF = sertx_pkg::NUM_HALF,
  localparam int unsigned WORD_W  = HALF_W * NUM_HALF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wr_data_i,
  input  logic              xfer_i,
  output logic [WORD_W-1:0] word_o,
  output logic              full_o,
  output logic              ovf_o
);
  logic commit;
  assign commit = wr_en_i & ~wr_hi_i;

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    localparam bit IS_UP = (h == NUM_HALF - 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          word_o[h*HALF_W +: HALF_W] <= '0;
      else if (wr_en_i && wr_hi_i == IS_UP) word_o[h*HALF_W +: HALF_W] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      ovf_o  <= 1'b0;
    end else begin
      full_o <= commit | (full_o & ~xfer_i);
      // a commit on top of a word that is not leaving this cycle overwrites it
      if (commit && full_o && !xfer_i) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int unsigned WORD_W  = sertx_pkg::WORD_W,
  parameter int unsigned MIN_LEN = sertx_pkg::MIN_LEN,
  localparam int unsigned CNT_W  = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [CNT_W-1:0]  len_m1_i,
  input  logic              fsync_i,
  output logic              sdo_o,
  output logic              loaded_o,
  output logic              active_o,
  output logic              last_o
);
  localparam logic [CNT_W-1:0] MIN_M1 = CNT_W'(MIN_LEN - 1);
  localparam logic [CNT_W-1:0] TOP_IX = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt, len_q, len_eff, align;

  assign len_eff  = (len_m1_i < MIN_M1) ? MIN_M1 : len_m1_i;
  assign align    = TOP_IX - len_eff;
  assign last_o   = active_o && (cnt == len_q);
  assign sdo_o    = active_o & shreg[WORD_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg    <= '0;
      cnt      <= '0;
      len_q    <= MIN_M1;
      loaded_o <= 1'b0;
      active_o <= 1'b0;
    end else begin
      if (active_o) begin
        if (last_o) active_o <= 1'b0;
        else begin
          shreg <= shreg << 1;
          cnt   <= cnt + 1'b1;
        end
      end else if (loaded_o && fsync_i) begin
        active_o <= 1'b1;
        loaded_o <= 1'b0;
        cnt      <= '0;
      end
      // reload has priority; only asserted when empty or on the last bit
      if (load_i) begin
        shreg    <= word_i << align;
        len_q    <= len_eff;
        loaded_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sertx_dbuf_tx.sv
module sertx_dbuf_tx #(
  parameter int unsigned HALF_W   = sertx_pkg::HALF_W,
  parameter int unsigned NUM_HALF = sertx_pkg::NUM_HALF,
  parameter int unsigned MIN_LEN  = sertx_pkg::MIN_LEN,
  localparam int unsigned WORD_W  = HALF_W * NUM_HALF,
  localparam int unsigned CNT_W   = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0]  len_m1_i,
  input  logic              fsync_i,
  output logic              sdo_o,
  output logic              tx_ready_o,
  output logic              ovf_o
);
  logic [WORD_W-1:0] hold_word;
  logic hold_full, sh_loaded, sh_active, sh_last, xfer;

  assign xfer       = hold_full & (~(sh_loaded | sh_active) | sh_last);
  assign tx_ready_o = ~hold_full;

  sertx_hold #(.HALF_W(HALF_W), .NUM_HALF(NUM_HALF)) u_hold (
    .clk_i, .rst_ni, .wr_en_i, .wr_hi_i, .wr_data_i,
    .xfer_i (xfer),
    .word_o (hold_word),
    .full_o (hold_full),
    .ovf_o  (ovf_o)
  );

  sertx_shifter #(.WORD_W(WORD_W), .MIN_LEN(MIN_LEN)) u_shift (
    .clk_i, .rst_ni,
    .load_i   (xfer),
    .word_i   (hold_word),
    .len_m1_i (len_m1_i),
    .fsync_i  (fsync_i),
    .sdo_o    (sdo_o),
    .loaded_o (sh_loaded),
    .active_o (sh_active),
    .last_o   (sh_last)
  );
endmodule

// File: rtl/sertx_dbuf_tx_chk.sv
module sertx_dbuf_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_en_i,
  input logic wr_hi_i,
  input logic fsync_i,
  input logic sdo_o,
  input logic tx_ready_o,
  input logic ovf_o,
  input logic hold_full,
  input logic sh_loaded,
  input logic sh_active
);
  AST_COMMIT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_hi_i |=> !tx_ready_o); // R2
  AST_XFER_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_full && !sh_loaded && !sh_active && !(wr_en_i && !wr_hi_i) |=> sh_loaded && tx_ready_o); // R3
  AST_XFER_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_full && sh_loaded |=> hold_full); // R4
  AST_HOLD_NO_FSYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_loaded && !sh_active && !fsync_i |=> !sh_active); // R5
  AST_START_ON_FSYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_loaded && !sh_active && fsync_i |=> sh_active); // R5
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sh_active |-> !sdo_o); // R8
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R10
endmodule

bind sertx_dbuf_tx sertx_dbuf_tx_chk u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_hi_i, .fsync_i, .sdo_o, .tx_ready_o, .ovf_o,
  .hold_full (hold_full),
  .sh_loaded (sh_loaded),
  .sh_active (sh_active)
);

// File: tb/sertx_dbuf_tx_tb_top.sv
module sertx_dbuf_tx_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en = 1'b0, wr_hi = 1'b0, fsync = 1'b0;
  logic [15:0] wr_data = '0;
  logic [4:0]  len_m1 = 5'd7;
  logic sdo, tx_ready, ovf;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sertx_dbuf_tx dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_hi_i(wr_hi),
    .wr_data_i(wr_data), .len_m1_i(len_m1), .fsync_i(fsync),
    .sdo_o(sdo), .tx_ready_o(tx_ready), .ovf_o(ovf)
  );

  typedef struct packed {
    logic [15:0] hi;
    logic [15:0] lo;
    logic [4:0]  lm1;
    logic [5:0]  exp_len;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'hA5C3, 16'h0F1E, 5'd31, 6'd32},
    '{16'h0000, 16'h00B7, 5'd7,  6'd8},
    '{16'hFFFF, 16'h8001, 5'd15, 6'd16},
    '{16'h0012, 16'h3456, 5'd23, 6'd24},
    '{16'h0000, 16'h005A, 5'd2,  6'd8},
    '{16'h0001, 16'h8000, 5'd16, 6'd17}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic hi, input logic [15:0] d);
    wr_en = 1'b1; wr_hi = hi; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic commit(input logic [15:0] hi, input logic [15:0] lo, input logic [4:0] lm1);
    len_m1 = lm1;
    wr(1'b1, hi);
    wr(1'b0, lo);
  endtask

  task automatic fs_pulse;
    fsync = 1'b1;
    @(negedge clk);
    fsync = 1'b0;
  endtask

  task automatic capture(input int len, output logic [31:0] got);
    got = '0;
    for (int k = 0; k < len; k++) begin
      got[len-1-k] = sdo;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] mask(input logic [31:0] w, input int len);
    return (len >= 32) ? w : (w & ((32'h1 << len) - 1));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] got, exp;
    repeat (3) @(negedge clk);
    chk({sdo, tx_ready, ovf} == 3'b010, "R1 in reset", {29'd0, sdo, tx_ready, ovf}, 32'h2);
    rst_ni = 1'b1;
    @(negedge clk);
    chk({sdo, tx_ready, ovf} == 3'b010, "R1 after reset", {29'd0, sdo, tx_ready, ovf}, 32'h2);

    foreach (VECS[i]) begin
      commit(VECS[i].hi, VECS[i].lo, VECS[i].lm1);
      chk(!tx_ready, "R2 commit clears ready", {31'd0, tx_ready}, 0);
      @(negedge clk);
      chk(tx_ready, "R3 immediate transfer", {31'd0, tx_ready}, 1);
      repeat (2) @(negedge clk);
      chk(!sdo, "R5 no start without fsync", {31'd0, sdo}, 0);
      fs_pulse();
      capture(int'(VECS[i].exp_len), got);
      exp = mask({VECS[i].hi, VECS[i].lo}, int'(VECS[i].exp_len));
      chk(got == exp, "R6 R7 serial word", got, exp);
      chk(!sdo, "R8 line low after word", {31'd0, sdo}, 0);
    end

    // R8: fsync with nothing loaded is not remembered
    fs_pulse();
    commit(16'h0000, 16'h00FF, 5'd7);
    repeat (4) @(negedge clk);
    chk(!sdo, "R8 stale fsync ignored", {31'd0, sdo}, 0);
    fs_pulse();
    capture(8, got);
    chk(got == 32'hFF, "R8 word after real fsync", got, 32'hFF);

    // R4 / R9: queue a word mid-shift, mid-word fsync
    commit(16'h0000, 16'h00C3, 5'd7);
    @(negedge clk);
    fs_pulse();
    got = '0;
    for (int k = 0; k < 8; k++) begin
      got[7-k] = sdo;
      case (k)
        1: begin wr_en = 1'b1; wr_hi = 1'b1; wr_data = 16'h0000; end
        2: begin wr_hi = 1'b0; wr_data = 16'h0096; end
        3: begin wr_en = 1'b0; fsync = 1'b1; end
        4: fsync = 1'b0;
        5: chk(!tx_ready, "R4 word held while busy", {31'd0, tx_ready}, 0);
        default: ;
      endcase
      @(negedge clk);
    end
    chk(got == 32'hC3, "R9 mid-word fsync ignored", got, 32'hC3);
    chk(tx_ready && !sdo, "R4 transfer at last bit", {30'd0, tx_ready, sdo}, 32'h2);
    repeat (2) @(negedge clk);
    chk(!sdo, "R4 queued word waits for fsync", {31'd0, sdo}, 0);
    fs_pulse();
    capture(8, got);
    chk(got == 32'h96, "R4 queued word sent", got, 32'h96);

    // R10: overwrite of pending word
    commit(16'h0000, 16'h0011, 5'd7);
    @(negedge clk);
    commit(16'h0000, 16'h0022, 5'd7);
    chk(!ovf, "R10 no flag on first queued word", {31'd0, ovf}, 0);
    commit(16'h0000, 16'h0033, 5'd7);
    chk(ovf, "R10 flag on overwrite", {31'd0, ovf}, 1);
    fs_pulse();
    capture(8, got);
    chk(got == 32'h11, "R10 loaded word intact", got, 32'h11);
    fs_pulse();
    capture(8, got);
    chk(got == 32'h33, "R10 newer word replaces older", got, 32'h33);
    chk(ovf, "R10 flag sticky", {31'd0, ovf}, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule